// File: doc/BRIEF.md
# Dispatch Width Throttle With Carry-Over

This block decides, one request at a time, whether an instruction of a given micro-op count may be dispatched in the current dispatch cycle. Each dispatch cycle offers a fixed budget of micro-op slots equal to the configured width. A dispatch cycle can span several clocks, and its boundary is marked by a strobe. An instruction wider than the budget is still admitted, but only while the whole budget is untouched. The part beyond the width is carried into later dispatch cycles and reduces the budget those cycles start with.

A grant also needs three readiness inputs from the surrounding pipeline: reorder buffer space, free rename registers and scheduler buffer space. Any request that is refused is counted as a stall. Three further saturating counters attribute each refusal with room in the budget to the first failing readiness input, checked in a fixed priority order.

Top module: `dispatch_throttle`

## Requirements
- R1: After reset the free slot count equals WIDTH, the carry-over is 0 and all four stall counters are 0.
- R2: A request of `reqUops` micro-ops fits when `reqUops` is at most the free slot count, or when the free slot count still equals WIDTH (an oversized request fits only then).
- R3: `grant` is high in the same clock exactly when `reqValid` is high, the request fits, and `robReady`, `renameReady` and `schedReady` are all high.
- R4: A granted request with `reqUops` no greater than the free slot count lowers the free slot count by `reqUops` at the next edge. A request of 0 micro-ops is granted and leaves it unchanged.
- R5: A granted request larger than the free slot count sets the free slot count to 0 and adds `reqUops - WIDTH` to the carry-over.
- R6: With `cycleEnd` high, the edge first applies that clock's dispatch. It then sets the free slot count to 0 if the carry-over is at least WIDTH, and to WIDTH minus the carry-over otherwise, and lowers the carry-over by WIDTH, not below 0.
- R7: Without `cycleEnd`, a clock with no grant leaves the free slot count and carry-over unchanged.
- R8: `stallTotal` rises by one after every clock with `reqValid` high and `grant` low, including refusals for lack of slots.
- R9: When a valid request fits but is refused, exactly one cause counter rises. `stallRob` rises if `robReady` is low. Otherwise `stallRename` rises if `renameReady` is low. Otherwise `stallSched` rises.
- R10: Every stall counter holds at 2^CNT_W-1 instead of wrapping.
- R11: While the carry-over is non-zero, the free slot count reads 0.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is presented this clock |
| reqUops | input | UOP_W | Micro-op count of the request |
| robReady | input | 1 | Reorder buffer can take the instruction |
| renameReady | input | 1 | Enough rename registers for the outputs |
| schedReady | input | 1 | Scheduler buffers can take the instruction |
| cycleEnd | input | 1 | This clock closes the current dispatch cycle |
| grant | output | 1 | The request is dispatched this clock |
| availEntries | output | SLOT_W | Free micro-op slots in the current dispatch cycle |
| carryOver | output | UOP_W | Micro-ops owed to later dispatch cycles |
| stallTotal | output | CNT_W | Refused valid requests |
| stallRob | output | CNT_W | Refusals blamed on the reorder buffer |
| stallRename | output | CNT_W | Refusals blamed on rename space |
| stallSched | output | CNT_W | Refusals blamed on the scheduler |

## Verification
On every clock, the assertions check that a grant never goes out without all three readiness inputs and that an oversized grant happens only with a full budget. They also check that the budget stays within the width, that a pending carry-over pins the budget at zero, and that the stall total never moves backwards and counts each refusal. The arithmetic of the budget and carry-over cannot be checked that way, so it is left to the bench's scenarios. These cover partial consumption within one dispatch cycle, carry-overs below, equal to and above the width draining over several boundaries, the priority among the cause counters, and saturation after a long run of stalls.

// File: rtl/dt_pkg.sv
package dt_pkg;
  // Strobes from the control to the datapath for one clock.
  typedef struct packed {
    logic grant;     // dispatch this clock
    logic oversize;  // granted request exceeds free slots
    logic cycleEnd;  // apply the cycle boundary update
    logic stallAny;  // valid request refused
    logic stallRob;  // refusal blamed on reorder buffer
    logic stallRen;  // refusal blamed on rename
    logic stallSch;  // refusal blamed on scheduler
  } dtStrobes_t;
endpackage

// File: rtl/dt_ctrl.sv
module dt_ctrl
  import dt_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter int UOP_W  = 4,
  parameter int SLOT_W = $clog2(WIDTH + 1)
) (
  input  logic              reqValid,
  input  logic [UOP_W-1:0]  reqUops,
  input  logic              robReady,
  input  logic              renameReady,
  input  logic              schedReady,
  input  logic              cycleEnd,
  input  logic [SLOT_W-1:0] availEntries,
  output logic              grant,
  output dtStrobes_t        strobes
);
  logic fullBudget;
  logic withinFree;
  logic fits;
  logic allReady;

  always_comb begin
    fullBudget = (32'(availEntries) == WIDTH);
    withinFree = (32'(reqUops) <= 32'(availEntries));
    fits       = withinFree || fullBudget;
    allReady   = robReady && renameReady && schedReady;
    grant      = reqValid && fits && allReady;

    strobes.grant    = grant;
    strobes.oversize = grant && !withinFree;
    strobes.cycleEnd = cycleEnd;
    strobes.stallAny = reqValid && !grant;
    // Cause attribution in fixed priority, only when slots were available.
    strobes.stallRob = reqValid && fits && !robReady;
    strobes.stallRen = reqValid && fits && robReady && !renameReady;
    strobes.stallSch = reqValid && fits && robReady && renameReady && !schedReady;
  end
endmodule

// File: rtl/dt_datapath.sv
module dt_datapath
  import dt_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter int UOP_W  = 4,
  parameter int CNT_W  = 8,
  parameter int SLOT_W = $clog2(WIDTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dtStrobes_t        strobes,
  input  logic [UOP_W-1:0]  reqUops,
  output logic [SLOT_W-1:0] availEntries,
  output logic [UOP_W-1:0]  carryOver,
  output logic [CNT_W-1:0]  stallTotal,
  output logic [CNT_W-1:0]  stallRob,
  output logic [CNT_W-1:0]  stallRename,
  output logic [CNT_W-1:0]  stallSched
);
  localparam int NUM_CNT = 4;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [SLOT_W-1:0] availQ, availD;
  logic [UOP_W-1:0]  carryQ, carryD;
  int                availMid;
  int                carryMid;

  // Dispatch effect first, then the optional cycle boundary.
  always_comb begin
    availMid = 32'(availQ);
    carryMid = 32'(carryQ);
    if (strobes.grant) begin
      if (strobes.oversize) begin
        availMid = 0;
        carryMid = 32'(carryQ) + 32'(reqUops) - WIDTH;
      end else begin
        availMid = 32'(availQ) - 32'(reqUops);
      end
    end
    availD = SLOT_W'(availMid);
    carryD = UOP_W'(carryMid);
    if (strobes.cycleEnd) begin
      if (carryMid >= WIDTH) begin
        availD = '0;
        carryD = UOP_W'(carryMid - WIDTH);
      end else begin
        availD = SLOT_W'(WIDTH - carryMid);
        carryD = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      availQ <= SLOT_W'(WIDTH);
      carryQ <= '0;
    end else begin
      availQ <= availD;
      carryQ <= carryD;
    end
  end

  logic [NUM_CNT-1:0] cntInc;
  logic [CNT_W-1:0]   cntQ [NUM_CNT];

  assign cntInc = {strobes.stallSch, strobes.stallRen, strobes.stallRob, strobes.stallAny};

  for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cntQ[gi] <= '0;
      end else if (cntInc[gi] && cntQ[gi] != CNT_MAX) begin
        cntQ[gi] <= cntQ[gi] + 1'b1;
      end
    end
  end

  assign availEntries = availQ;
  assign carryOver    = carryQ;
  assign stallTotal   = cntQ[0];
  assign stallRob     = cntQ[1];
  assign stallRename  = cntQ[2];
  assign stallSched   = cntQ[3];
endmodule

// File: rtl/dispatch_throttle.sv
module dispatch_throttle
  import dt_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter int UOP_W  = 4,
  parameter int CNT_W  = 8,
  localparam int SLOT_W = $clog2(WIDTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [UOP_W-1:0]  reqUops,
  input  logic              robReady,
  input  logic              renameReady,
  input  logic              schedReady,
  input  logic              cycleEnd,
  output logic              grant,
  output logic [SLOT_W-1:0] availEntries,
  output logic [UOP_W-1:0]  carryOver,
  output logic [CNT_W-1:0]  stallTotal,
  output logic [CNT_W-1:0]  stallRob,
  output logic [CNT_W-1:0]  stallRename,
  output logic [CNT_W-1:0]  stallSched
);
  dtStrobes_t strobes;

  dt_ctrl #(.WIDTH(WIDTH), .UOP_W(UOP_W), .SLOT_W(SLOT_W)) ctrl_i (
    .reqValid    (reqValid),
    .reqUops     (reqUops),
    .robReady    (robReady),
    .renameReady (renameReady),
    .schedReady  (schedReady),
    .cycleEnd    (cycleEnd),
    .availEntries(availEntries),
    .grant       (grant),
    .strobes     (strobes)
  );

  dt_datapath #(.WIDTH(WIDTH), .UOP_W(UOP_W), .CNT_W(CNT_W), .SLOT_W(SLOT_W)) dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .reqUops     (reqUops),
    .availEntries(availEntries),
    .carryOver   (carryOver),
    .stallTotal  (stallTotal),
    .stallRob    (stallRob),
    .stallRename (stallRename),
    .stallSched  (stallSched)
  );
endmodule

// File: rtl/dispatch_throttle_chk.sv
module dispatch_throttle_chk #(
  parameter int WIDTH  = 4,
  parameter int UOP_W  = 4,
  parameter int CNT_W  = 8,
  parameter int SLOT_W = $clog2(WIDTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqValid,
  input logic [UOP_W-1:0]  reqUops,
  input logic              robReady,
  input logic              renameReady,
  input logic              schedReady,
  input logic              grant,
  input logic [SLOT_W-1:0] availEntries,
  input logic [UOP_W-1:0]  carryOver,
  input logic [CNT_W-1:0]  stallTotal
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  p_grant_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (reqValid && robReady && renameReady && schedReady));

  p_oversize_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && 32'(reqUops) > WIDTH) |-> (32'(availEntries) == WIDTH));

  p_avail_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(availEntries) <= WIDTH);

  p_carry_pins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (carryOver != '0) |-> (availEntries == '0));

  p_stall_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !grant && stallTotal != CNT_MAX) |=> (stallTotal == $past(stallTotal) + 1'b1));

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stallTotal == CNT_MAX) |=> (stallTotal == CNT_MAX));
endmodule

bind dispatch_throttle dispatch_throttle_chk #(
  .WIDTH(WIDTH), .UOP_W(UOP_W), .CNT_W(CNT_W), .SLOT_W(SLOT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqUops(reqUops),
  .robReady(robReady), .renameReady(renameReady), .schedReady(schedReady),
  .grant(grant), .availEntries(availEntries), .carryOver(carryOver),
  .stallTotal(stallTotal)
);

// File: tb/dispatch_throttle_tb.sv
module dispatch_throttle_tb_top;
  localparam int PERIOD = 10;
  localparam int WIDTH  = 4;
  localparam int UOP_W  = 4;
  localparam int CNT_W  = 8;
  localparam int SLOT_W = $clog2(WIDTH + 1);
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic clk = 0;
  logic rst_n = 0;
  logic reqValid = 0;
  logic [UOP_W-1:0] reqUops = '0;
  logic robReady = 1, renameReady = 1, schedReady = 1, cycleEnd = 0;
  logic grant;
  logic [SLOT_W-1:0] availEntries;
  logic [UOP_W-1:0] carryOver;
  logic [CNT_W-1:0] stallTotal, stallRob, stallRename, stallSched;

  always #(PERIOD/2) clk = ~clk;

  dispatch_throttle #(.WIDTH(WIDTH), .UOP_W(UOP_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqUops(reqUops),
    .robReady(robReady), .renameReady(renameReady), .schedReady(schedReady),
    .cycleEnd(cycleEnd), .grant(grant), .availEntries(availEntries),
    .carryOver(carryOver), .stallTotal(stallTotal), .stallRob(stallRob),
    .stallRename(stallRename), .stallSched(stallSched)
  );

  typedef struct {
    string tag;
    bit    eGrant;
    int    eA, eC, eT, eRob, eRen, eSch;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  bit monBusy = 0;
  bit finished = 0;

  // Independent reference state.
  int mA = WIDTH, mC = 0, mT = 0, mRob = 0, mRen = 0, mSch = 0;

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic sat(ref int c);
    if (c < CMAX) c++;
  endtask

  // Driver: applies one clock of stimulus and pushes the expected outcome.
  task automatic drive(string tag, bit v, int u, bit rb, bit rn, bit sc, bit ce);
    item_t it;
    bit fits, g;
    int a1, c1;
    @(negedge clk);
    reqValid = v; reqUops = UOP_W'(u); robReady = rb; renameReady = rn;
    schedReady = sc; cycleEnd = ce;
    #1;
    fits = (u <= mA) || (mA == WIDTH);
    g = v && fits && rb && rn && sc;
    a1 = mA; c1 = mC;
    if (g) begin
      if (u <= mA) a1 = mA - u;
      else begin a1 = 0; c1 = mC + u - WIDTH; end
    end
    if (ce) begin
      if (c1 >= WIDTH) begin mA = 0; mC = c1 - WIDTH; end
      else begin mA = WIDTH - c1; mC = 0; end
    end else begin
      mA = a1; mC = c1;
    end
    if (v && !g) sat(mT);
    if (v && fits && !rb) sat(mRob);
    else if (v && fits && !rn) sat(mRen);
    else if (v && fits && !sc) sat(mSch);
    it.tag = tag; it.eGrant = g; it.eA = mA; it.eC = mC; it.eT = mT;
    it.eRob = mRob; it.eRen = mRen; it.eSch = mSch;
    q.push_back(it);
  endtask

  // Monitor: grant right after the inputs settle, state after the edge.
  initial begin
    forever begin
      item_t it;
      bit g;
      wait (q.size() > 0);
      monBusy = 1;
      it = q.pop_front();
      g = grant;
      @(posedge clk);
      #1;
      check(it.tag, "grant", int'(g), int'(it.eGrant));
      check(it.tag, "availEntries", int'(availEntries), it.eA);
      check(it.tag, "carryOver", int'(carryOver), it.eC);
      check(it.tag, "stallTotal", int'(stallTotal), it.eT);
      check(it.tag, "stallRob", int'(stallRob), it.eRob);
      check(it.tag, "stallRename", int'(stallRename), it.eRen);
      check(it.tag, "stallSched", int'(stallSched), it.eSch);
      monBusy = 0;
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R1: reset state
    check("R1", "availEntries", int'(availEntries), WIDTH);
    check("R1", "carryOver", int'(carryOver), 0);
    check("R1", "stallTotal", int'(stallTotal), 0);
    check("R1", "counters", int'(stallRob) + int'(stallRename) + int'(stallSched), 0);

    // R4: partial consumption inside one dispatch cycle; R7: no refill
    drive("R4", 1, 2, 1, 1, 1, 0);
    drive("R7", 0, 0, 1, 1, 1, 0);
    // R2: 3 > 2 free and budget not full -> refused (slot stall, R8)
    drive("R2", 1, 3, 1, 1, 1, 0);
    drive("R4", 1, 0, 1, 1, 1, 0);
    drive("R6", 1, 2, 1, 1, 1, 1);
    // R5: oversized, carry 3 < WIDTH
    drive("R5", 1, 7, 1, 1, 1, 1);
    drive("R2", 1, 2, 1, 1, 1, 1);
    // R5/R6: carry 7 drains over two boundaries
    drive("R5", 1, 11, 1, 1, 1, 1);
    drive("R11", 1, 1, 1, 1, 1, 0);
    drive("R6", 0, 0, 1, 1, 1, 1);
    drive("R6", 0, 0, 1, 1, 1, 1);
    // Carry exactly WIDTH: 8 uops
    drive("R5", 1, 8, 1, 1, 1, 1);
    drive("R6", 0, 0, 1, 1, 1, 1);
    drive("R6", 1, 4, 1, 1, 1, 1);
    // R3/R9: readiness and cause priority
    drive("R9", 1, 1, 0, 0, 0, 0);
    drive("R9", 1, 1, 1, 0, 0, 0);
    drive("R9", 1, 1, 1, 1, 0, 0);
    drive("R3", 1, 1, 1, 1, 1, 0);
    drive("R3", 0, 1, 1, 1, 1, 1);
    // Refusal for slots with a readiness low: no cause counted
    drive("R4", 1, 4, 1, 1, 1, 0);
    drive("R9", 1, 2, 0, 1, 1, 0);
    drive("R6", 0, 0, 1, 1, 1, 1);
    // R10: saturation of total and reorder-buffer counters
    for (int i = 0; i < CMAX + 4; i++) drive("R10", 1, 1, 0, 1, 1, 1);
    drive("R8", 1, 15, 1, 1, 0, 1);

    @(negedge clk);
    reqValid = 0;
    wait (q.size() == 0 && !monBusy);
    @(negedge clk);
    summary();
  end
endmodule